// File: doc/BRIEF.md
# External Bus Sizing Sequencer

This block sits between a 32-bit load/store path and a 16-bit external data bus. It takes one request for a byte, half-word or word and runs as many external cycles as the selected device width needs. It supports 16-bit and 8-bit devices. Each cycle drives an address, the write data on the correct byte lane(s) and active-low lane strobes. For reads it collects the returned bytes in a holding register, then zero- or sign-extends the result to 32 bits. Byte-lane steering follows a per-request endian bit. In big-endian mode the lower address maps to the upper lane, and an 8-bit device sits on the upper lane.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while external cycles run, so a held `req_valid` simply waits and its fields may change until acceptance. The first external cycle is the clock after acceptance, and each cycle lasts exactly one clock. `done` pulses for one clock after the last cycle, with the read result on `rd_data`. `req_ready` is high again in that same clock, so back-to-back requests lose no cycle.

Top module: `bus_sizer`

## Requirements
- R1: `bus_cycle` is high for exactly N consecutive clocks, starting the clock after acceptance. N is set by `req_size` (0 byte, 1 half-word, 2 or 3 word) and device width. For a 16-bit device, a word takes 2 cycles and a half-word or byte takes 1. For an 8-bit device, a word takes 4, a half-word 2 and a byte 1.
- R2: Cycle addresses ascend from an aligned base. The base is the address with bit 0 cleared for a half-word and bits 1:0 cleared for a word. A byte uses the address unchanged. A 16-bit device steps by 2 and an 8-bit device steps by 1.
- R3: On a 16-bit device, a half-word drives register byte 0 on the low lane and byte 1 on the high lane. A word's first cycle carries bytes 1:0 in little-endian mode and bytes 3:2 in big-endian mode, with the odd-numbered byte on the high lane.
- R4: On a 16-bit device, a byte uses the low lane when address bit 0 XOR the endian bit is 0, and the high lane otherwise. `bus_lo_n` (bits 7:0) and `bus_hi_n` (bits 15:8) are low only for lanes in use, and both are high when no cycle runs.
- R5: An 8-bit device uses lane bits 7:0 in little-endian mode and 15:8 in big-endian mode, with only that lane's strobe active. Little-endian sends register byte 0 first; big-endian sends the most significant byte of the access first.
- R6: A read result places the byte from the lowest address in the least significant position (little-endian) or the most significant position (big-endian). Byte and half-word results are sign-extended when `req_signed` is 1 and zero-extended otherwise.
- R7: The value on a lane whose strobe is inactive during a read cycle has no effect on `rd_data`.
- R8: `bus_wdata` changes only on lanes strobed in a write cycle. An unused lane keeps its previous value, and reads leave `bus_wdata` unchanged.
- R9: `done` is high for exactly one clock, the clock after the last cycle, and `rd_data` then holds the read result.
- R10: `req_ready` is low exactly while cycles run. A request offered then is not taken and does not alter the running sequence.
- R11: In reset, `req_ready` is 1, `bus_cycle` and `done` are 0, both strobes are 1 and `bus_wdata` is 0. A reset during a sequence abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_write | input | 1 | 1 store, 0 load |
| req_signed | input | 1 | Sign-extend a byte/half-word load |
| req_wdata | input | 32 | Store data, right-aligned |
| dev_is_8bit | input | 1 | Device is 8 bits wide |
| area_big_endian | input | 1 | Area uses big-endian lane order |
| bus_addr | output | AW | External cycle address |
| bus_wdata | output | 16 | External write data |
| bus_rdata | input | 16 | External read data, sampled at the end of each cycle |
| bus_lo_n | output | 1 | Lane 7:0 strobe, active low |
| bus_hi_n | output | 1 | Lane 15:8 strobe, active low |
| bus_cycle | output | 1 | An external cycle runs this clock |
| rd_data | output | 32 | Assembled, extended load result |
| done | output | 1 | Sequence finished last clock |

## Verification
Two things fall in the same clock: the `done` pulse that presents a finished read, and acceptance of the next request. Acceptance clears the holding register that feeds `rd_data`. The stimulus table is walked back to back, offering each request in the done clock of the previous one. The bench then checks the previous result on `rd_data` in that clock and the first cycle of the new request in the next. A separate run holds a different request valid through a whole sequence to show it is neither taken nor mixed in.

// File: rtl/sizer_pkg.sv
package sizer_pkg;
  localparam int REG_BYTES = 4;
  localparam int LANES     = 2;
  localparam int REG_W     = REG_BYTES * 8;
  localparam int BUS_W     = LANES * 8;
  localparam int TGT_W     = $clog2(REG_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } acc_size_e;

  // one external cycle: which lanes are used and which register byte each carries
  typedef struct packed {
    logic [LANES-1:0]            en;
    logic [LANES-1:0][TGT_W-1:0] tgt;
    logic                        last;
  } beat_t;
endpackage

// File: rtl/sizer_beat_plan.sv
module sizer_beat_plan
  import sizer_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr,
  input  acc_size_e     size,
  input  logic          dev8,
  input  logic          be,
  input  logic [1:0]    idx,
  output logic [AW-1:0] beat_addr,
  output beat_t         beat
);
  logic [AW-1:0]    base;
  logic [1:0]       off;
  logic             is_word;
  logic             half_sel;
  logic             lane;
  logic [TGT_W-1:0] t8;

  assign is_word = (size == SZ_WORD) || (size == SZ_WRSV);

  always_comb begin
    base     = addr;
    off      = 2'd0;
    beat     = '0;
    half_sel = 1'b0;
    lane     = 1'b0;
    t8       = '0;
    unique case (size)
      SZ_BYTE: base = addr;
      SZ_HALF: base = {addr[AW-1:1], 1'b0};
      default: base = {addr[AW-1:2], 2'b00};
    endcase
    if (!dev8) begin
      if (is_word) begin
        // big-endian puts the upper half at the lower address
        half_sel    = idx[0] ^ be;
        beat.en     = 2'b11;
        beat.tgt[0] = {half_sel, 1'b0};
        beat.tgt[1] = {half_sel, 1'b1};
        off         = {idx[0], 1'b0};
        beat.last   = idx[0];
      end else if (size == SZ_HALF) begin
        beat.en     = 2'b11;
        beat.tgt[0] = 2'd0;
        beat.tgt[1] = 2'd1;
        beat.last   = 1'b1;
      end else begin
        lane        = addr[0] ^ be;
        beat.en     = lane ? 2'b10 : 2'b01;
        beat.last   = 1'b1;
      end
    end else begin
      beat.en = be ? 2'b10 : 2'b01;
      if (is_word) begin
        t8        = be ? ~idx : idx;
        off       = idx;
        beat.last = &idx;
      end else if (size == SZ_HALF) begin
        t8        = {1'b0, idx[0] ^ be};
        off       = {1'b0, idx[0]};
        beat.last = idx[0];
      end else begin
        beat.last = 1'b1;
      end
      beat.tgt[0] = t8;
      beat.tgt[1] = t8;
    end
    beat_addr = base + AW'(off);
  end
endmodule

// File: rtl/sizer_seq.sv
module sizer_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       cur_last,
  output logic       req_ready,
  output logic       accept,
  output logic       advance,
  output logic       finish,
  output logic [1:0] idx_next,
  output logic       done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;
  st_e        st;
  logic [1:0] idx;

  assign req_ready = (st != ST_RUN);
  assign accept    = req_valid && req_ready;
  assign advance   = (st == ST_RUN) && !cur_last;
  assign finish    = (st == ST_RUN) && cur_last;
  assign idx_next  = accept ? 2'd0 : idx + 2'd1;
  assign done      = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= 2'd0;
    end else if (accept) begin
      st  <= ST_RUN;
      idx <= 2'd0;
    end else begin
      unique case (st)
        ST_RUN: begin
          if (cur_last) st <= ST_DONE;
          else          idx <= idx + 2'd1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sizer_bus_drive.sv
module sizer_bus_drive
  import sizer_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        finish,
  input  logic                        wr_next,
  input  logic [AW-1:0]               beat_addr,
  input  beat_t                       beat,
  input  logic [REG_W-1:0]            wsrc,
  output logic [AW-1:0]               bus_addr,
  output logic [BUS_W-1:0]            bus_wdata,
  output logic [LANES-1:0]            strobe_n,
  output logic                        bus_cycle,
  output logic [LANES-1:0][TGT_W-1:0] cur_tgt,
  output logic                        cur_last
);
  logic [REG_BYTES-1:0][7:0] wbytes;
  assign wbytes = wsrc;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bus_wdata[g*8 +: 8] <= 8'h00;
        strobe_n[g]         <= 1'b1;
        cur_tgt[g]          <= '0;
      end else if (load) begin
        if (wr_next && beat.en[g]) bus_wdata[g*8 +: 8] <= wbytes[beat.tgt[g]];
        strobe_n[g] <= ~beat.en[g];
        cur_tgt[g]  <= beat.tgt[g];
      end else if (finish) begin
        strobe_n[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_cycle <= 1'b0;
      cur_last  <= 1'b0;
    end else if (load) begin
      bus_addr  <= beat_addr;
      bus_cycle <= 1'b1;
      cur_last  <= beat.last;
    end else if (finish) begin
      bus_cycle <= 1'b0;
      cur_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/sizer_rd_assemble.sv
module sizer_rd_assemble
  import sizer_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        cap,
  input  logic [LANES-1:0]            en,
  input  logic [LANES-1:0][TGT_W-1:0] tgt,
  input  logic [BUS_W-1:0]            bus_rdata,
  input  acc_size_e                   size,
  input  logic                        sgn,
  output logic [REG_W-1:0]            rd_data
);
  logic [REG_BYTES-1:0][7:0] hold;

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold[b] <= 8'h00;
      end else if (clear) begin
        hold[b] <= 8'h00;
      end else if (cap) begin
        if (en[0] && (tgt[0] == TGT_W'(b)))      hold[b] <= bus_rdata[7:0];
        else if (en[1] && (tgt[1] == TGT_W'(b))) hold[b] <= bus_rdata[15:8];
      end
    end
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: rd_data = {{24{sgn & hold[0][7]}}, hold[0]};
      SZ_HALF: rd_data = {{16{sgn & hold[1][7]}}, hold[1], hold[0]};
      default: rd_data = hold;
    endcase
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import sizer_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic          req_signed,
  input  logic [31:0]   req_wdata,
  input  logic          dev_is_8bit,
  input  logic          area_big_endian,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  output logic          bus_lo_n,
  output logic          bus_hi_n,
  output logic          bus_cycle,
  output logic [31:0]   rd_data,
  output logic          done
);
  logic          accept, advance, finish, cur_last;
  logic [1:0]    idx_next;
  logic [AW-1:0] cap_addr, p_addr, beat_addr;
  acc_size_e     cap_size, p_size;
  logic          cap_dev8, cap_be, cap_wr, cap_sgn;
  logic          p_dev8, p_be, p_wr;
  logic [REG_W-1:0] cap_wdata, p_wdata;
  beat_t         beat;
  logic [LANES-1:0]            strobe_n;
  logic [LANES-1:0][TGT_W-1:0] cur_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_size  <= SZ_BYTE;
      cap_dev8  <= 1'b0;
      cap_be    <= 1'b0;
      cap_wr    <= 1'b0;
      cap_sgn   <= 1'b0;
      cap_wdata <= '0;
    end else if (accept) begin
      cap_addr  <= req_addr;
      cap_size  <= acc_size_e'(req_size);
      cap_dev8  <= dev_is_8bit;
      cap_be    <= area_big_endian;
      cap_wr    <= req_write;
      cap_sgn   <= req_signed;
      cap_wdata <= req_wdata;
    end
  end

  // the first cycle is planned straight from the request, later ones from the copy
  assign p_addr  = accept ? req_addr               : cap_addr;
  assign p_size  = accept ? acc_size_e'(req_size)  : cap_size;
  assign p_dev8  = accept ? dev_is_8bit            : cap_dev8;
  assign p_be    = accept ? area_big_endian        : cap_be;
  assign p_wr    = accept ? req_write              : cap_wr;
  assign p_wdata = accept ? req_wdata              : cap_wdata;

  sizer_seq u_seq (
    .clk, .rst_n, .req_valid, .cur_last,
    .req_ready, .accept, .advance, .finish, .idx_next, .done
  );

  sizer_beat_plan #(.AW(AW)) u_plan (
    .addr(p_addr), .size(p_size), .dev8(p_dev8), .be(p_be),
    .idx(idx_next), .beat_addr, .beat
  );

  sizer_bus_drive #(.AW(AW)) u_drive (
    .clk, .rst_n,
    .load(accept || advance), .finish,
    .wr_next(p_wr), .beat_addr, .beat, .wsrc(p_wdata),
    .bus_addr, .bus_wdata, .strobe_n, .bus_cycle, .cur_tgt, .cur_last
  );

  sizer_rd_assemble u_rd (
    .clk, .rst_n, .clear(accept),
    .cap(bus_cycle && !cap_wr),
    .en(~strobe_n), .tgt(cur_tgt), .bus_rdata,
    .size(cap_size), .sgn(cap_sgn), .rd_data
  );

  assign bus_lo_n = strobe_n[0];
  assign bus_hi_n = strobe_n[1];
endmodule

// File: rtl/sizer_checker.sv
module sizer_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] bus_wdata,
  input logic        bus_lo_n,
  input logic        bus_hi_n,
  input logic        bus_cycle,
  input logic        done
);
  AST_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_cycle);                                  // R1
  AST_LANE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cycle |-> !(bus_lo_n && bus_hi_n));                                 // R4
  AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cycle |-> (bus_lo_n && bus_hi_n));                                 // R4
  AST_LO_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lo_n |-> $stable(bus_wdata[7:0]));                                  // R8
  AST_HI_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hi_n |-> $stable(bus_wdata[15:8]));                                 // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                        // R9
  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_cycle));                                      // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cycle |-> !req_ready);                                              // R10
endmodule

bind bus_sizer sizer_checker u_chk (
  .clk, .rst_n, .req_valid, .req_ready, .bus_wdata,
  .bus_lo_n, .bus_hi_n, .bus_cycle, .done
);

// File: tb/sim_bus_sizer.sv
`timescale 1ns/1ps
module sim_bus_sizer;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd0;
  logic          req_write = 1'b0;
  logic          req_signed = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          dev_is_8bit = 1'b0;
  logic          area_big_endian = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata = '0;
  logic          bus_lo_n, bus_hi_n, bus_cycle, done;
  logic [31:0]   rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] prev_wd = 16'h0000;

  always #2.5 clk = ~clk;

  bus_sizer #(.AW(AW)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_size, .req_write,
    .req_signed, .req_wdata, .dev_is_8bit, .area_big_endian, .bus_addr,
    .bus_wdata, .bus_rdata, .bus_lo_n, .bus_hi_n, .bus_cycle, .rd_data, .done
  );

  // {dev8, be, size[1:0], write, signed, 2'b0, addr[7:0], wdata[31:0]}
  localparam int NV = 20;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0,1'b0,2'd2,1'b1,1'b0,2'b0,8'h00,32'hA1B2C3D4},
    {1'b0,1'b1,2'd2,1'b1,1'b0,2'b0,8'h04,32'h5E6F7081},
    {1'b0,1'b0,2'd2,1'b0,1'b0,2'b0,8'h08,32'h0},
    {1'b0,1'b1,2'd3,1'b0,1'b0,2'b0,8'h0C,32'h0},
    {1'b0,1'b0,2'd1,1'b1,1'b0,2'b0,8'h02,32'h00009A7E},
    {1'b0,1'b1,2'd1,1'b0,1'b1,2'b0,8'h06,32'h0},
    {1'b0,1'b0,2'd0,1'b1,1'b0,2'b0,8'h03,32'h0000005C},
    {1'b0,1'b1,2'd0,1'b1,1'b0,2'b0,8'h03,32'h000000E9},
    {1'b0,1'b0,2'd0,1'b0,1'b1,2'b0,8'h01,32'h0},
    {1'b0,1'b1,2'd0,1'b0,1'b0,2'b0,8'h00,32'h0},
    {1'b1,1'b0,2'd2,1'b1,1'b0,2'b0,8'h10,32'h13579BDF},
    {1'b1,1'b1,2'd2,1'b1,1'b0,2'b0,8'h14,32'h2468ACE0},
    {1'b1,1'b0,2'd2,1'b0,1'b0,2'b0,8'h18,32'h0},
    {1'b1,1'b1,2'd2,1'b0,1'b0,2'b0,8'h1C,32'h0},
    {1'b1,1'b0,2'd1,1'b0,1'b1,2'b0,8'h22,32'h0},
    {1'b1,1'b1,2'd1,1'b1,1'b0,2'b0,8'h26,32'h0000C3A5},
    {1'b1,1'b1,2'd0,1'b0,1'b1,2'b0,8'h2B,32'h0},
    {1'b1,1'b0,2'd0,1'b1,1'b0,2'b0,8'h2D,32'h0000007D},
    {1'b0,1'b0,2'd1,1'b0,1'b0,2'b0,8'h05,32'h0},
    {1'b1,1'b1,2'd2,1'b0,1'b0,2'b0,8'h1F,32'h0}
  };

  function automatic logic [7:0] mem_at(input logic [AW-1:0] y);
    logic [7:0] lo;
    lo = y[7:0];
    return (lo * 8'd113) + 8'h8B;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drives one request at the current negedge and follows it to its done clock.
  // Returns at the negedge inside the done clock, with req_valid still set as left.
  task automatic run_seq(input logic [47:0] v, input bit noisy);
    bit dev8, be, wr, sgn;
    logic [1:0] sz;
    int n, nb;
    logic [AW-1:0] a, base, ea, y;
    logic [31:0] wd, expv;
    logic [1:0] es_n;
    logic [15:0] ew, rdrv;
    string ltag;
    dev8 = v[47]; be = v[46]; sz = v[45:44]; wr = v[43]; sgn = v[42];
    a    = {16'h4C00, v[39:32]};
    wd   = v[31:0];
    n    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    base = a & ~AW'(n - 1);
    nb   = dev8 ? n : ((n == 4) ? 2 : 1);
    if (dev8) ltag = "R5";
    else if (n == 1) ltag = wr ? "R8" : "R4";
    else ltag = "R3";
    chk(req_ready == 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_signed = sgn; req_wdata = wd; dev_is_8bit = dev8; area_big_endian = be;
    @(posedge clk);
    @(negedge clk);
    if (noisy) begin
      req_valid = 1'b1; req_addr = 24'h00_00EE; req_size = 2'd2; req_write = 1'b1;
      req_wdata = 32'hDEADBEEF; dev_is_8bit = ~dev8; area_big_endian = ~be;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k < nb; k++) begin
      if (dev8)        ea = base + AW'(k);
      else if (n == 1) ea = a;
      else             ea = base + AW'(2 * k);
      es_n = 2'b11; ew = prev_wd; rdrv = 16'h3CC3 ^ 16'(k);
      for (int l = 0; l < 2; l++) begin
        bit present;
        int idx, ri;
        y = dev8 ? ea : {ea[AW-1:1], 1'(l) ^ be};
        present = dev8 ? (l == int'(be)) : ((y >= base) && (y < base + AW'(n)));
        if (present) begin
          idx = int'(y - base);
          ri  = be ? (n - 1 - idx) : idx;
          es_n[l] = 1'b0;
          if (wr) ew[l*8 +: 8] = wd[ri*8 +: 8];
          rdrv[l*8 +: 8] = mem_at(y);
        end
      end
      chk(bus_cycle == 1'b1, "R1 cycle active", 64'(bus_cycle), 64'd1);
      chk(bus_addr == ea, "R2 cycle address", 64'(bus_addr), 64'(ea));
      chk({bus_hi_n, bus_lo_n, bus_wdata} == {es_n, ew}, ltag,
          64'({bus_hi_n, bus_lo_n, bus_wdata}), 64'({es_n, ew}));
      chk(!req_ready && !done, "R10 busy", 64'({req_ready, done}), 64'd0);
      bus_rdata = rdrv;
      prev_wd   = bus_wdata;
      @(negedge clk);
    end
    chk(bus_cycle == 1'b0 && done == 1'b1, "R9 done after last cycle R1",
        64'({bus_cycle, done}), 64'b01);
    if (!wr) begin
      expv = '0;
      for (int i = 0; i < n; i++) begin
        int pos;
        pos = be ? (n - 1 - i) : i;
        expv[pos*8 +: 8] = mem_at(base + AW'(i));
      end
      if (n == 1) expv = {{24{sgn & expv[7]}}, expv[7:0]};
      if (n == 2) expv = {{16{sgn & expv[15]}}, expv[15:0]};
      chk(rd_data == expv, (dev8 || n == 1) ? "R7 read with idle lane R6" : "R6 read assembly",
          64'(rd_data), 64'(expv));
    end
  endtask

  bit finished = 1'b0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({req_ready, bus_cycle, done, bus_hi_n, bus_lo_n} == 5'b10011 && bus_wdata == 16'h0,
        "R11 reset outputs", 64'({req_ready, bus_cycle, done, bus_hi_n, bus_lo_n, bus_wdata}),
        64'({5'b10011, 16'h0}));
    rst_n = 1'b1;
    @(negedge clk);

    // table walked back to back: each next request is offered in the done clock
    for (int i = 0; i < NV; i++) run_seq(VEC[i], 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1 && bus_cycle == 1'b0, "R9 done lasts one clock",
        64'({done, req_ready, bus_cycle}), 64'b010);

    // a different request held valid through a running sequence
    run_seq({1'b1,1'b0,2'd2,1'b0,1'b0,2'b0,8'h40,32'h0}, 1'b1);
    req_valid = 1'b0;
    @(negedge clk);
    chk(bus_cycle == 1'b0 && req_ready == 1'b1, "R10 held request not taken",
        64'({bus_cycle, req_ready}), 64'b01);

    // R8: word write then a byte write to the low lane: high lane must keep byte 3 of the word
    run_seq({1'b0,1'b0,2'd2,1'b1,1'b0,2'b0,8'h50,32'h77665544}, 1'b0);
    run_seq({1'b0,1'b0,2'd0,1'b1,1'b0,2'b0,8'h52,32'h000000AB}, 1'b0);
    req_valid = 1'b0;
    chk(bus_wdata == 16'h77AB, "R8 unused lane keeps value", 64'(bus_wdata), 64'h77AB);
    // a read leaves the write lanes alone
    run_seq({1'b0,1'b1,2'd2,1'b0,1'b0,2'b0,8'h60,32'h0}, 1'b0);
    req_valid = 1'b0;
    chk(bus_wdata == 16'h77AB, "R8 read keeps write data", 64'(bus_wdata), 64'h77AB);
    @(negedge clk);

    // R11: reset in the middle of an 8-bit word sequence
    req_valid = 1'b1; req_addr = 24'h4C0070; req_size = 2'd2; req_write = 1'b1;
    req_wdata = 32'h0BADF00D; dev_is_8bit = 1'b1; area_big_endian = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({req_ready, bus_cycle, done, bus_hi_n, bus_lo_n} == 5'b10011 && bus_wdata == 16'h0,
        "R11 reset mid sequence", 64'({req_ready, bus_cycle, done, bus_hi_n, bus_lo_n, bus_wdata}),
        64'({5'b10011, 16'h0}));
    @(negedge clk);
    rst_n = 1'b1;
    prev_wd = 16'h0000;
    @(negedge clk);
    chk(bus_cycle == 1'b0, "R11 sequence abandoned", 64'(bus_cycle), 64'd0);
    run_seq({1'b1,1'b1,2'd1,1'b0,1'b1,2'b0,8'h8A,32'h0}, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule